// File: doc/BRIEF.md
# Polyphase Horizontal Line Scaler

This block resamples one line of single-component pixel samples from a source width to a destination width. A line is first taken in over a valid/ready input stream and held in a small sample store. The block then walks a fixed-point position through that line. The position has 13 fraction bits. For each output sample, the integer part of the position picks the centre source sample. The top four fraction bits pick one of 16 filter phases. A 7-tap FIR filter then combines the centre sample with its three neighbours on each side, using that phase's coefficients. The result goes out on a valid/ready output stream.

Software-side state arrives on plain input ports. These are the source and destination widths (each given as width minus one), a signed start position and an unsigned step increment. A write port fills the coefficient bank. Each phase's seven 12-bit coefficients are spread over three 28-bit words. After reset the bank holds a pass-through filter, so the block copies or nearest-neighbour resamples until it is given other coefficients. The configuration inputs must stay stable while a line is in flight. They are sampled again for every new line.

Top module: `scl_line_scaler`

## Requirements
- R1: After reset the block is ready to accept input (`in_ready_o`=1) with `out_valid_o`=0. Every phase of the coefficient bank holds 1024 on tap 3 and 0 on all other taps.
- R2: The block accepts exactly `src_wm1_i`+1 input samples per line, for source widths from 1 to MAX_W. In the cycle after the last one is accepted, it stops accepting input and presents its first output.
- R3: Exactly `dst_wm1_i`+1 outputs are produced per line. After the last output handshake, the block returns to accepting input with `out_valid_o`=0, and the position is reloaded from `start_i`.
- R4: Output k uses position P = start + k*inc, with 13 fraction bits. The centre sample index is floor(P / 8192), and the phase is bits 12:9 of P taken as two's complement.
- R5: Tap t (0..6) multiplies source sample centre+t-3. Indices below 0 use sample 0, and indices above the last sample use the last sample.
- R6: The output is (sum of coefficient x sample + 512) shifted right arithmetically by 10. The result is clamped to the range 0 to 2^SAMPLE_W-1.
- R7: A coefficient write addresses word `addr[5:4]` of phase `addr[3:0]`. Word 0 holds tap0 in 27:16, tap1 in 15:4 and tap2 bits 11:8 in 3:0. Word 1 holds tap2 bits 7:0 in 27:20, tap3 in 19:8 and tap4 bits 11:4 in 7:0. Word 2 holds tap4 bits 3:0 in 27:24, tap5 in 23:12 and tap6 in 11:0. All coefficients are two's complement.
- R8: Coefficient writes with `addr[5:4]`=3 change nothing.
- R9: Negative start positions are honoured. For example, -2048 is a quarter sample before sample 0, and it selects centre -1 with phase 12.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_valid_o` hold.
- R11: With a bank holding 1024 on tap 3 only, each output equals the edge-clamped source sample at floor(P / 8192).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_wm1_i | input | 12 | Source width minus one |
| dst_wm1_i | input | 12 | Destination width minus one |
| start_i | input | 19 | Signed start position, 13 fraction bits |
| inc_i | input | 16 | Step per output, 13 fraction bits |
| coef_we_i | input | 1 | Coefficient word write strobe |
| coef_addr_i | input | 6 | {word select, phase} |
| coef_wdata_i | input | 28 | Coefficient word |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when high |
| in_data_i | input | SAMPLE_W | Input sample |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Output sample taken when high |
| out_data_o | output | SAMPLE_W | Scaled output sample |

## Verification
The bench builds the block with MAX_W=16 and SAMPLE_W=8. With so small a store, every line reaches both clamped edges, and a destination-width sweep from 2 to 16 at two start offsets lands on all 16 phases. The 8-bit sample range lets a bank with a strong negative lobe, fed alternating full-scale and zero samples, drive the sum past both clamp limits. Lines of width one, negative starts and stalled output handshakes are run with the same arithmetic model of position, tap selection and rounding.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int PHASES    = 16;
  localparam int PH_W      = 4;
  localparam int TAPS      = 7;
  localparam int CTR       = 3;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 10;
  localparam int FRAC_W    = 13;
  localparam int WORD_W    = 28;
  localparam int WSEL_W    = 2;
  localparam int CADDR_W   = WSEL_W + PH_W;
  localparam int DIM_W     = 12;
  localparam int INC_W     = 16;
  localparam int START_W   = 19;
  localparam int ACC_W     = 30;
  localparam int IDX_W     = ACC_W - FRAC_W;

  typedef enum logic {ST_FILL, ST_EMIT} mode_e;
endpackage

// File: rtl/scl_coef_bank.sv
module scl_coef_bank
  import scl_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [CADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  input  logic [PH_W-1:0]               phase_i,
  output logic [TAPS-1:0][COEF_W-1:0]   taps_o
);
  localparam logic [WORD_W-1:0] IDENT_W1 = WORD_W'(1 << COEF_FRAC) << 8;

  logic [2:0][PHASES-1:0][WORD_W-1:0] bank_q;
  logic [WSEL_W-1:0] wsel;
  logic [PH_W-1:0]   wph;
  logic [WORD_W-1:0] w0, w1, w2;

  assign wsel = addr_i[CADDR_W-1:PH_W];
  assign wph  = addr_i[PH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      for (int p = 0; p < PHASES; p++) bank_q[1][p] <= IDENT_W1;
    end else if (we_i && wsel != 2'd3) begin
      bank_q[wsel][wph] <= wdata_i;
    end
  end

  assign w0 = bank_q[0][phase_i];
  assign w1 = bank_q[1][phase_i];
  assign w2 = bank_q[2][phase_i];

  // taps straddle word boundaries at tap2 and tap4
  assign taps_o[0] = w0[27:16];
  assign taps_o[1] = w0[15:4];
  assign taps_o[2] = {w0[3:0], w1[27:20]};
  assign taps_o[3] = w1[19:8];
  assign taps_o[4] = {w1[7:0], w2[27:24]};
  assign taps_o[5] = w2[23:12];
  assign taps_o[6] = w2[11:0];

  assert_ignore_wsel3_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wsel == 2'd3) |=> $stable(bank_q));
endmodule

// File: rtl/scl_phase_acc.sv
module scl_phase_acc
  import scl_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      step_i,
  input  logic signed [START_W-1:0] start_i,
  input  logic [INC_W-1:0]          inc_i,
  output logic signed [IDX_W-1:0]   centre_o,
  output logic [PH_W-1:0]           phase_o
);
  logic signed [ACC_W-1:0] pos_q;
  logic signed [ACC_W-1:0] inc_x;

  assign inc_x = $signed({{(ACC_W-INC_W){1'b0}}, inc_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (load_i)  pos_q <= ACC_W'(start_i);
    else if (step_i)  pos_q <= pos_q + inc_x;
  end

  // integer part is floor for negative positions too
  assign centre_o = pos_q[ACC_W-1:FRAC_W];
  assign phase_o  = pos_q[FRAC_W-1 -: PH_W];
endmodule

// File: rtl/scl_line_store.sv
module scl_line_store
  import scl_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int DEPTH    = 64,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 waddr_i,
  input  logic [SAMPLE_W-1:0]           wdata_i,
  input  logic signed [IDX_W-1:0]       centre_i,
  input  logic [DIM_W-1:0]              lim_i,
  output logic [TAPS-1:0][SAMPLE_W-1:0] win_o
);
  logic [DEPTH-1:0][SAMPLE_W-1:0] mem_q;
  logic signed [IDX_W:0] cen_x, lim_x;

  assign cen_x = {centre_i[IDX_W-1], centre_i};
  assign lim_x = {{(IDX_W+1-DIM_W){1'b0}}, lim_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    localparam logic signed [IDX_W:0] OFS = (IDX_W+1)'(g - CTR);
    logic signed [IDX_W:0] raw;
    logic [AW-1:0] idx;
    assign raw = cen_x + OFS;
    always_comb begin
      if (raw < 0)          idx = '0;
      else if (raw > lim_x) idx = lim_i[AW-1:0];
      else                  idx = raw[AW-1:0];
    end
    assign win_o[g] = mem_q[idx];
  end

  assert_width_fits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (lim_i < DIM_W'(DEPTH)));
endmodule

// File: rtl/scl_fir.sv
module scl_fir
  import scl_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [TAPS-1:0][COEF_W-1:0]   coef_i,
  input  logic [TAPS-1:0][SAMPLE_W-1:0] win_i,
  output logic [SAMPLE_W-1:0]           res_o
);
  localparam int PROD_W = COEF_W + SAMPLE_W + 1;
  localparam int SUM_W  = PROD_W + 3;
  localparam logic signed [SUM_W-1:0] HALF  = SUM_W'(1 << (COEF_FRAC - 1));
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << SAMPLE_W) - 1);

  logic signed [PROD_W-1:0] ce, se, prod;
  logic signed [SUM_W-1:0]  acc, rnd, shf;

  always_comb begin
    acc = '0;
    ce = '0;
    se = '0;
    prod = '0;
    for (int t = 0; t < TAPS; t++) begin
      ce   = PROD_W'($signed(coef_i[t]));
      se   = PROD_W'($signed({1'b0, win_i[t]}));
      prod = ce * se;
      acc  = acc + SUM_W'(prod);
    end
    rnd = acc + HALF;
    shf = rnd >>> COEF_FRAC;
    if (shf < 0)          res_o = '0;
    else if (shf > MAX_S) res_o = MAX_S[SAMPLE_W-1:0];
    else                  res_o = shf[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/scl_line_scaler.sv
module scl_line_scaler
  import scl_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int MAX_W    = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [11:0]               src_wm1_i,
  input  logic [11:0]               dst_wm1_i,
  input  logic signed [18:0]        start_i,
  input  logic [15:0]               inc_i,
  input  logic                      coef_we_i,
  input  logic [5:0]                coef_addr_i,
  input  logic [27:0]               coef_wdata_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [SAMPLE_W-1:0]       in_data_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [SAMPLE_W-1:0]       out_data_o
);
  localparam int AW = $clog2(MAX_W);

  mode_e mode_q;
  logic [AW-1:0]    wr_idx_q;
  logic [DIM_W-1:0] out_cnt_q;
  logic in_fire, out_fire, last_in, last_out;
  logic signed [IDX_W-1:0] centre;
  logic [PH_W-1:0] phase;
  logic [TAPS-1:0][COEF_W-1:0]   taps;
  logic [TAPS-1:0][SAMPLE_W-1:0] win;

  assign in_ready_o  = (mode_q == ST_FILL);
  assign out_valid_o = (mode_q == ST_EMIT);
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;
  assign last_in     = (DIM_W'(wr_idx_q) == src_wm1_i);
  assign last_out    = (out_cnt_q == dst_wm1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= ST_FILL;
      wr_idx_q  <= '0;
      out_cnt_q <= '0;
    end else if (mode_q == ST_FILL) begin
      if (in_fire) begin
        if (last_in) begin
          wr_idx_q <= '0;
          mode_q   <= ST_EMIT;
        end else begin
          wr_idx_q <= wr_idx_q + 1'b1;
        end
      end
    end else if (out_fire) begin
      if (last_out) begin
        out_cnt_q <= '0;
        mode_q    <= ST_FILL;
      end else begin
        out_cnt_q <= out_cnt_q + 1'b1;
      end
    end
  end

  scl_phase_acc u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (mode_q == ST_FILL),
    .step_i   (out_fire),
    .start_i  (start_i),
    .inc_i    (inc_i),
    .centre_o (centre),
    .phase_o  (phase)
  );

  scl_line_store #(.SAMPLE_W(SAMPLE_W), .DEPTH(MAX_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (in_fire),
    .waddr_i  (wr_idx_q),
    .wdata_i  (in_data_i),
    .centre_i (centre),
    .lim_i    (src_wm1_i),
    .win_o    (win)
  );

  scl_coef_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (coef_we_i),
    .addr_i  (coef_addr_i),
    .wdata_i (coef_wdata_i),
    .phase_i (phase),
    .taps_o  (taps)
  );

  scl_fir #(.SAMPLE_W(SAMPLE_W)) u_fir (
    .coef_i (taps),
    .win_i  (win),
    .res_o  (out_data_o)
  );

  assert_emit_after_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && last_in) |=> (out_valid_o && !in_ready_o));

  assert_refill_after_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && last_out) |=> (in_ready_o && !out_valid_o));

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_cnt_q <= dst_wm1_i));

  assert_hold_on_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !coef_we_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: tb/tb_scl_line_scaler.sv
module tb_scl_line_scaler;
  localparam int SW = 8;
  localparam int MW = 16;

  logic clk, rst_n;
  logic [11:0] src_wm1, dst_wm1;
  logic signed [18:0] start_v;
  logic [15:0] inc_v;
  logic coef_we;
  logic [5:0] coef_addr;
  logic [27:0] coef_wdata;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [SW-1:0] in_data, out_data;

  int checks = 0;
  int fails = 0;
  int line_s[MW];
  int ctap[16][7];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  scl_line_scaler #(.SAMPLE_W(SW), .MAX_W(MW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_wm1_i(src_wm1), .dst_wm1_i(dst_wm1),
    .start_i(start_v), .inc_i(inc_v),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_wdata_i(coef_wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R4 R5 R6: position, edge-clamped taps, rounding and clamping
  function automatic int model(int k, int srcw, int start, int inc);
    longint pos, ci, ix, acc;
    int ph;
    pos = longint'(start) + longint'(k) * longint'(inc);
    ci  = pos >>> 13;
    ph  = int'((pos >>> 9) & 15);
    acc = 0;
    for (int t = 0; t < 7; t++) begin
      ix = ci + t - 3;
      if (ix < 0) ix = 0;
      if (ix > srcw - 1) ix = srcw - 1;
      acc += longint'(ctap[ph][t]) * longint'(line_s[int'(ix)]);
    end
    acc = (acc + 512) >>> 10;
    if (acc < 0) acc = 0;
    if (acc > 255) acc = 255;
    return int'(acc);
  endfunction

  task automatic wr_word(int ws, int ph, int val);
    @(negedge clk);
    coef_we = 1'b1;
    coef_addr = 6'(ws * 16 + ph);
    coef_wdata = 28'(val);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // R7: pack the model taps into the three-word layout
  task automatic load_bank();
    for (int p = 0; p < 16; p++) begin
      int c[7];
      int w0, w1, w2;
      for (int t = 0; t < 7; t++) c[t] = ctap[p][t] & 'hfff;
      w0 = (c[0] << 16) | (c[1] << 4) | (c[2] >> 8);
      w1 = ((c[2] & 'hff) << 20) | (c[3] << 8) | (c[4] >> 4);
      w2 = ((c[4] & 'hf) << 24) | (c[5] << 12) | c[6];
      wr_word(0, p, w0);
      wr_word(1, p, w1);
      wr_word(2, p, w2);
    end
  endtask

  task automatic set_identity();
    for (int p = 0; p < 16; p++)
      for (int t = 0; t < 7; t++) ctap[p][t] = (t == 3) ? 1024 : 0;
  endtask

  task automatic set_smooth();
    for (int p = 0; p < 16; p++) begin
      ctap[p][0] = -8;       ctap[p][1] = 24 + p;
      ctap[p][2] = 200 - 8*p; ctap[p][3] = 600;
      ctap[p][4] = 200 + 8*p; ctap[p][5] = 16 - p;
      ctap[p][6] = -8 - 8*p + 8*p;
    end
  endtask

  task automatic set_sharp();
    for (int p = 0; p < 16; p++)
      for (int t = 0; t < 7; t++)
        ctap[p][t] = (t == 3) ? 1824 : ((t == 2 || t == 4) ? -400 : 0);
  endtask

  task automatic run_line(string tag, int srcw, int dstw, int start, int inc, int stall_mod);
    int held;
    bit have_held;
    @(negedge clk);
    src_wm1 = 12'(srcw - 1);
    dst_wm1 = 12'(dstw - 1);
    start_v = 19'(start);
    inc_v   = 16'(inc);
    for (int i = 0; i < srcw; i++) begin
      bit got;
      in_valid = 1'b1;
      in_data  = SW'(line_s[i]);
      got = 1'b0;
      while (!got) begin
        got = in_ready;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    have_held = 1'b0;
    for (int k = 0; k < dstw; k++) begin
      bit done_k;
      int cyc;
      done_k = 1'b0;
      cyc = 0;
      while (!done_k) begin
        out_ready = (stall_mod == 0) || ((cyc % stall_mod) != 0);
        cyc++;
        #1;
        if (out_valid && have_held) begin
          check({tag, " R10 hold"}, int'(out_data), held);
          have_held = 1'b0;
        end
        if (out_valid && out_ready) begin
          check(tag, int'(out_data), model(k, srcw, start, inc));
          done_k = 1'b1;
        end else if (out_valid) begin
          held = int'(out_data);
          have_held = 1'b1;
        end
        @(negedge clk);
      end
    end
    out_ready = 1'b0;
    #1;
    check("R3 ready after last output", int'(in_ready), 1);
    check("R3 no valid after last output", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_wm1 = 12'd7; dst_wm1 = 12'd7; start_v = '0; inc_v = 16'd8192;
    coef_we = 1'b0; coef_addr = '0; coef_wdata = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in_ready in reset", int'(in_ready), 1);
    check("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // R1 R11: bank left at reset contents copies the line
    set_identity();
    for (int i = 0; i < MW; i++) line_s[i] = (i * 37 + 11) % 256;
    run_line("R1 R11 copy", 8, 8, 0, 8192, 0);
    run_line("R11 upscale x2", 8, 16, 0, 4096, 0);
    run_line("R11 downscale", 16, 5, 0, 26214, 0);

    // R8: writes to word select 3 leave the bank alone
    for (int p = 0; p < 16; p++) wr_word(3, p, 'h0fff_fff);
    run_line("R8 ignored writes", 12, 12, 8192, 8192, 0);

    // R4 R5 R7: programmed bank, destination sweep over all phases
    set_smooth();
    load_bank();
    for (int i = 0; i < MW; i++) line_s[i] = (i * 53 + 29) % 256;
    for (int d = 2; d <= 16; d++) begin
      int inc;
      inc = ((12 << 13) + (d >> 1)) / d;
      run_line("R4 R5 R7 sweep", 12, d, 0, inc, 0);
      run_line("R4 R5 R7 sweep offset", 12, d, 3000, inc, 0);
    end

    // R9: negative starts
    run_line("R9 quarter back", 10, 10, -2048, 8192, 0);
    run_line("R9 deep back", 10, 14, -6000, 5851, 0);

    // R2 R5: single-sample line
    run_line("R2 R5 width one", 1, 4, 0, 2048, 0);

    // R10: stalled output handshakes
    run_line("R10 stall", 12, 9, 1000, 10923, 3);

    // R6: overshoot in both directions
    set_sharp();
    load_bank();
    for (int i = 0; i < MW; i++) line_s[i] = (i % 2) ? 255 : 0;
    run_line("R6 clamp", 16, 16, 0, 8192, 0);
    run_line("R6 clamp half phase", 16, 16, 4096, 8192, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule